// File: doc/BRIEF.md
# Single-Cycle Five-Instruction Processor Core

This block is a 32-bit processor core that executes a small integer instruction subset: register add, add-immediate, set-if-less-than-immediate, word load and word store. Each instruction finishes within one clock period. In that period the core fetches the word at the program counter, splits it into fields, reads the register file, computes in the ALU, optionally touches data memory and writes back a result.

The core connects to two separate memories. The instruction port is an address output paired with a read-data input. The data port has an address, write data, a write enable and a read-data input. Both memories are read combinationally, and a store is committed on the same rising edge that advances the program counter. Encodings the core does not implement behave as no-ops. A synchronous active-high reset returns execution to address zero.

Top module: `sc_core`

## Requirements
- R1: On a rising edge with `rst` high the PC becomes 0. On every other rising edge it grows by 4. `imem_addr` always shows the PC.
- R2: Fields sit at fixed bit positions: opcode [31:26], first source [25:21], second source / immediate destination [20:16], register destination [15:11], function code [5:0], immediate [15:0]. The immediate is sign-extended to 32 bits.
- R3: Opcode 0x00 with function 0x20 writes the 32-bit wrapping sum of both source registers into the register destination.
- R4: Opcode 0x08 writes first source plus the extended immediate into register [20:16].
- R5: Opcode 0x0A writes 1 into register [20:16] when the first source is below the extended immediate, compared as signed values. Otherwise it writes 0.
- R6: Opcode 0x23 drives first source plus extended immediate on `dmem_addr` and writes `dmem_rdata` into register [20:16].
- R7: Opcode 0x2B drives first source plus extended immediate on `dmem_addr` and register [20:16] on `dmem_wdata`, and raises `dmem_we`. It writes no register.
- R8: No instruction other than opcode 0x2B raises `dmem_we`.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: Any other opcode, and opcode 0x00 with a function code other than 0x20, changes neither registers nor memory. The PC still advances.
- R11: While `rst` is high, neither the register file nor data memory is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
On every cycle the assertions check the PC sequence: it returns to zero after reset and steps by four otherwise. They also check that the store strobe appears exactly when the fetched opcode is a store, and never during reset. Arithmetic results, signed comparison, sign extension of offsets and the protection of register zero are not visible on any port in the cycle they happen. Only the bench scenarios can show them, by storing each destination register afterwards and comparing the store data against a reference model.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SLT = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;    // register write-back enable
    logic    dst_rd;   // destination from [15:11] instead of [20:16]
    logic    use_imm;  // ALU operand B is the extended immediate
    alu_op_e alu_op;
    logic    mem_we;   // data store
    logic    wb_mem;   // write-back takes load data
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{rf_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0,
             alu_op: ALU_ADD, mem_we: 1'b0, wb_mem: 1'b0};
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctrl.rf_we  = 1'b1;
          ctrl.dst_rd = 1'b1;
        end
      end
      OP_ADDI: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
      end
      OP_SLTI: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.alu_op  = ALU_SLT;
      end
      OP_LW: begin
        ctrl.rf_we   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int WIDTH = 32,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] store [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store[raddr_b];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] sum;
  logic             less;

  assign sum  = a + b;
  assign less = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_SLT: y = {{(WIDTH-1){1'b0}}, less};
      default: y = sum;
    endcase
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int IMM_W = 16;
  localparam int AW    = $clog2(NREG);

  logic [XLEN-1:0]   pc;
  logic [5:0]        opcode;
  logic [5:0]        funct;
  logic [AW-1:0]     rs_idx;
  logic [AW-1:0]     rt_idx;
  logic [AW-1:0]     rd_idx;
  logic [AW-1:0]     dst_idx;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   rs_val;
  logic [XLEN-1:0]   rt_val;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic [XLEN-1:0]   wb_val;
  logic              rf_we;
  ctrl_t             ctrl;
  logic              unused_shamt;

  // Program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else begin
      pc <= pc + XLEN'(4);
    end
  end

  assign imem_addr = pc;

  // Field split
  assign opcode       = imem_rdata[31:26];
  assign rs_idx       = imem_rdata[21 +: AW];
  assign rt_idx       = imem_rdata[16 +: AW];
  assign rd_idx       = imem_rdata[11 +: AW];
  assign funct        = imem_rdata[5:0];
  assign imm          = imem_rdata[IMM_W-1:0];
  assign unused_shamt = ^imem_rdata[10:6];
  assign imm_ext      = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  sc_decoder u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;
  assign rf_we   = ctrl.rf_we & ~rst;

  sc_regfile #(
    .WIDTH (XLEN),
    .NREG  (NREG)
  ) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (dst_idx),
    .wdata   (wb_val),
    .raddr_a (rs_idx),
    .raddr_b (rt_idx),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

  sc_alu #(
    .WIDTH (XLEN)
  ) u_alu (
    .op (ctrl.alu_op),
    .a  (rs_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  // Memory step and write-back select
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we & ~rst;
  assign wb_val     = ctrl.wb_mem ? dmem_rdata : alu_y;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_rdata,
  input logic        dmem_we
);

  logic run_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    run_q <= ~rst;
    rst_q <= rst;
  end

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> imem_addr == $past(imem_addr) + 32'd4);

  // R1
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      pc_reset_chk: assert (imem_addr == 32'h0);
    end
  end

  // R8
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> imem_rdata[31:26] == 6'h2B);

  // R7
  store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    imem_rdata[31:26] == 6'h2B |-> dmem_we);

  // R11
  always_ff @(posedge clk) begin
    if (rst) begin
      reset_quiet_chk: assert (!dmem_we);
    end
  end

endmodule

bind sc_core sc_core_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we)
);

// File: tb/sc_core_tb.sv
module sc_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MEMW       = 256;
  localparam int NRAND      = 90;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [MEMW];
  logic [31:0] dmem [MEMW];

  logic [31:0] m_pc;
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [MEMW];
  string       tag_of [MEMW];
  int          plen = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  sc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];

  always @(posedge clk) begin
    if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] sext(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic emit(logic [31:0] ins, string tag);
    imem[plen]   = ins;
    tag_of[plen] = tag;
    plen++;
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s pc=%h actual=%h expected=%h", req, what, m_pc, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check_cycle();
    logic [31:0] ins, ea;
    logic [5:0]  op;
    bit          is_sw, is_lw, known;
    string       wtag;
    ins   = imem[m_pc[9:2]];
    op    = ins[31:26];
    ea    = m_reg[ins[25:21]] + sext(ins[15:0]);
    is_sw = (op == 6'h2B);
    is_lw = (op == 6'h23);
    known = is_sw || is_lw || op == 6'h08 || op == 6'h0A ||
            (op == 6'h00 && ins[5:0] == 6'h20);
    check(imem_addr == m_pc, "R1", "imem_addr", imem_addr, m_pc);
    wtag = is_sw ? "R7" : (known ? "R8" : "R10");
    check(dmem_we == is_sw, wtag, "dmem_we", {31'd0, dmem_we}, {31'd0, is_sw});
    if (is_sw) begin
      check(dmem_addr == ea, "R7", "store address", dmem_addr, ea);
      check(dmem_wdata == m_reg[ins[20:16]], tag_of[m_pc[9:2]], "store data",
            dmem_wdata, m_reg[ins[20:16]]);
    end
    if (is_lw) begin
      check(dmem_addr == ea, "R6", "load address", dmem_addr, ea);
    end
  endtask

  task automatic step();
    logic [31:0] ins, a, b, ea, res;
    logic [5:0]  op;
    int          dst;
    bit          wr;
    ins = imem[m_pc[9:2]];
    op  = ins[31:26];
    a   = m_reg[ins[25:21]];
    b   = m_reg[ins[20:16]];
    ea  = a + sext(ins[15:0]);
    wr  = 1'b1;
    dst = int'(ins[20:16]);
    res = '0;
    if (op == 6'h00 && ins[5:0] == 6'h20) begin
      res = a + b;
      dst = int'(ins[15:11]);
    end else if (op == 6'h08) begin
      res = ea;
    end else if (op == 6'h0A) begin
      res = ($signed(a) < $signed(sext(ins[15:0]))) ? 32'd1 : 32'd0;
    end else if (op == 6'h23) begin
      res = m_mem[ea[9:2]];
    end else begin
      wr = 1'b0;
      if (op == 6'h2B) m_mem[ea[9:2]] = b;
    end
    if (wr && dst != 0) m_reg[dst] = res;
    m_pc = m_pc + 32'd4;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit did_rst;
    void'($urandom(32'd20240611));
    did_rst = 1'b0;
    for (int i = 0; i < MEMW; i++) begin
      imem[i]   = 32'h0;
      tag_of[i] = "R7";
      dmem[i]   = 32'hC3A50000 ^ (i * 32'h01010101);
      m_mem[i]  = dmem[i];
    end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;

    // Give every register a known value (R4)
    for (int r = 1; r < 32; r++) emit(enc_i(6'h08, 0, r, 16'($urandom)), "R4");

    // Directed corner cases
    emit(enc_i(6'h08, 0, 0, 16'h1234), "R9");
    emit(enc_i(6'h2B, 0, 0, 16'h0000), "R9");
    emit(enc_i(6'h08, 0, 5, 16'h0100), "R4");
    emit(enc_i(6'h08, 0, 6, 16'hFFFD), "R4");
    emit(enc_i(6'h2B, 5, 6, 16'hFFF8), "R2");      // negative offset, value -3
    emit(enc_i(6'h23, 5, 7, 16'hFFF8), "R6");
    emit(enc_i(6'h2B, 0, 7, 16'h0004), "R6");
    emit(enc_i(6'h0A, 6, 8, 16'hFFFE), "R5");      // -3 < -2 -> 1
    emit(enc_i(6'h2B, 0, 8, 16'h0008), "R5");
    emit(enc_i(6'h0A, 6, 9, 16'hFFFC), "R5");      // -3 < -4 -> 0
    emit(enc_i(6'h2B, 0, 9, 16'h000C), "R5");
    emit(enc_i(6'h0A, 5, 10, 16'hFFFF), "R5");     // 256 < -1 -> 0 (signed)
    emit(enc_i(6'h2B, 0, 10, 16'h0010), "R5");
    emit(enc_r(5, 6, 11, 6'h20), "R3");            // 256 + -3
    emit(enc_i(6'h2B, 0, 11, 16'h0014), "R3");
    emit(enc_i(6'h3F, 5, 11, 16'h0001), "R10");
    emit(enc_i(6'h2B, 0, 11, 16'h0018), "R10");
    emit(enc_r(5, 6, 11, 6'h22), "R10");
    emit(enc_i(6'h2B, 0, 11, 16'h001C), "R10");
    emit(enc_r(5, 5, 0, 6'h20), "R9");
    emit(enc_i(6'h2B, 0, 0, 16'h0020), "R9");

    // Constrained random pairs: operation, then a store of its result
    for (int i = 0; i < NRAND; i++) begin
      int    kind, d, s, t, k;
      string tg;
      kind = int'($urandom % 6);
      d    = int'($urandom % 32);
      s    = int'($urandom % 32);
      t    = int'($urandom % 32);
      k    = int'($urandom % 64);
      tg   = "R7";
      case (kind)
        0: begin emit(enc_r(s, t, d, 6'h20), "R3"); tg = "R3"; end
        1: begin emit(enc_i(6'h08, s, d, 16'($urandom)), "R4"); tg = "R4"; end
        2: begin emit(enc_i(6'h0A, s, d, 16'($urandom)), "R5"); tg = "R5"; end
        3: begin emit(enc_i(6'h23, 0, d, 16'(k * 4)), "R6"); tg = "R6"; end
        4: emit(enc_i(6'h2B, 0, t, 16'(k * 4)), "R7");
        default: begin emit(enc_i(6'h3F, s, d, 16'($urandom)), "R10"); tg = "R10"; end
      endcase
      if (kind != 4) begin
        emit(enc_i(6'h2B, 0, d, 16'(int'($urandom % 64) * 4)), (d == 0) ? "R9" : tg);
      end
    end

    // Reset
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst  = 1'b0;
    m_pc = 32'h0;
    check(imem_addr == 32'h0, "R1", "pc after reset", imem_addr, 32'h0);

    for (int c = 0; c < plen + 65; c++) begin
      logic [31:0] cur;
      cur = imem[m_pc[9:2]];
      if (!did_rst && c >= 60 && cur[31:26] == 6'h2B) begin
        rst = 1'b1;
        #1;
        check(dmem_we == 1'b0, "R11", "store strobe in reset", {31'd0, dmem_we}, 32'h0);
        @(negedge clk);
        rst  = 1'b0;
        m_pc = 32'h0;
        did_rst = 1'b1;
        check(imem_addr == 32'h0, "R1", "pc after mid-run reset", imem_addr, 32'h0);
      end
      check_cycle();
      step();
      @(negedge clk);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule